// File: doc/BRIEF.md
# Privilege-Filtered Access Mask Register Pair

This block keeps the access mask that a page permission checker consults, together with a second register that limits what unprivileged code may change in that mask. Requests arrive one per cycle. Each carries a register number, a privilege flag, a write flag and a data word. The access mask can be reached through two numbers. One number is open to user code. The other requires privilege. The filter register is reachable only with privilege.

When user code writes the mask through its open number, only the bit positions that the filter register allows are changed. All other bit positions are cleared. Privileged code always writes the full word. A user request that names a privileged-only number is refused: the block raises a denied flag and nothing changes. The current mask is always visible on a dedicated output, so the permission checker can use it.

Top module: `amask_regs`

## Requirements
- R1: After reset the access mask is all ones and the filter register is all zeros.
- R2: A user-mode write to register number 13 stores the write data bitwise-AND the filter register into the access mask.
- R3: A privileged write to register number 13 or 29 stores the full write data into the access mask, with no masking.
- R4: A privileged write to register number 157 stores the full write data into the filter register. A privileged read of 157 returns the filter register.
- R5: A read of number 13 returns the access mask in both user and privileged mode. A privileged read of number 29 also returns the access mask.
- R6: A user-mode request to number 29 or 157 asserts `req_denied` in that cycle, returns zero read data and changes neither register.
- R7: A write takes effect at the next rising clock edge. Read data in the same cycle shows the value held before that write.
- R8: A request to any other register number is not denied, returns zero read data and changes neither register. A cycle without `req_vld` changes nothing.
- R9: `amask_o` always shows the current access mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | A request is present this cycle |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_num | input | 10 | Register number |
| req_priv | input | 1 | 1 when the requester is privileged |
| req_wdata | input | 64 | Write data |
| req_rdata | output | 64 | Read data, combinational from the current register value |
| req_denied | output | 1 | User request to a privileged-only number |
| amask_o | output | 64 | Current access mask, sent to the permission checker |

## Verification
The hard case is a masked user write whose result differs from both the data and the old mask. To reach it, the filter register must first hold a non-trivial pattern, and that register can only be loaded through a privileged write. The bench sweeps every combination of register number, privilege and direction over a sequence of data words. This sequence interleaves privileged writes to the filter with user writes to the open alias. As a result, each user write meets a different filter value. A bench-side model computes each expected value with AND arithmetic.

// File: rtl/amask_regs.sv
module amask_regs #(
  parameter int DATA_W    = 64,
  parameter int NUM_W     = 10,
  parameter int USR_ALIAS = 13,
  parameter int PRV_ALIAS = 29,
  parameter int FILT_NUM  = 157
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              req_wr,
  input  logic [NUM_W-1:0]  req_num,
  input  logic              req_priv,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] req_rdata,
  output logic              req_denied,
  output logic [DATA_W-1:0] amask_o
);
  localparam logic [NUM_W-1:0] N_USR  = NUM_W'(USR_ALIAS);
  localparam logic [NUM_W-1:0] N_PRV  = NUM_W'(PRV_ALIAS);
  localparam logic [NUM_W-1:0] N_FILT = NUM_W'(FILT_NUM);

  logic [DATA_W-1:0] amask_q, filt_q;
  logic sel_usr, sel_prv, sel_filt, grant, hit_mask, wr_mask, wr_filt;

  assign sel_usr  = req_num == N_USR;
  assign sel_prv  = req_num == N_PRV;
  assign sel_filt = req_num == N_FILT;

  assign req_denied = req_vld & ~req_priv & (sel_prv | sel_filt);
  assign grant      = req_vld & ~req_denied;
  assign hit_mask   = grant & (sel_usr | sel_prv);
  assign wr_mask    = hit_mask & req_wr;
  assign wr_filt    = grant & sel_filt & req_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amask_q <= '1;
      filt_q  <= '0;
    end else begin
      if (wr_mask) amask_q <= req_priv ? req_wdata : (req_wdata & filt_q);
      if (wr_filt) filt_q  <= req_wdata;
    end
  end

  always_comb begin
    req_rdata = '0;
    if (hit_mask)              req_rdata = amask_q;
    else if (grant & sel_filt) req_rdata = filt_q;
  end

  assign amask_o = amask_q;
endmodule

module amask_regs_chk #(
  parameter int DATA_W    = 64,
  parameter int NUM_W     = 10,
  parameter int USR_ALIAS = 13,
  parameter int PRV_ALIAS = 29,
  parameter int FILT_NUM  = 157
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic              req_wr,
  input logic [NUM_W-1:0]  req_num,
  input logic              req_priv,
  input logic [DATA_W-1:0] req_wdata,
  input logic [DATA_W-1:0] req_rdata,
  input logic              req_denied,
  input logic [DATA_W-1:0] amask_o,
  input logic [DATA_W-1:0] filt_q
);
  logic usr_wr, prv_wr, locked;
  assign usr_wr = req_vld & req_wr & ~req_priv & (req_num == NUM_W'(USR_ALIAS));
  assign prv_wr = req_vld & req_wr & req_priv &
                  ((req_num == NUM_W'(USR_ALIAS)) | (req_num == NUM_W'(PRV_ALIAS)));
  assign locked = req_vld & ~req_priv &
                  ((req_num == NUM_W'(PRV_ALIAS)) | (req_num == NUM_W'(FILT_NUM)));

  AST_USER_WRITE_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
    usr_wr |=> amask_o == ($past(req_wdata) & $past(filt_q))); // R2
  AST_PRIV_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    prv_wr |=> amask_o == $past(req_wdata)); // R3
  AST_DENY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (req_denied && req_rdata == '0)); // R6
  AST_DENY_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    req_denied |=> ($stable(amask_o) && $stable(filt_q))); // R6
  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> ($stable(amask_o) && $stable(filt_q))); // R8
  AST_NO_SPURIOUS_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !req_denied); // R8
endmodule

bind amask_regs amask_regs_chk #(
  .DATA_W(DATA_W), .NUM_W(NUM_W), .USR_ALIAS(USR_ALIAS),
  .PRV_ALIAS(PRV_ALIAS), .FILT_NUM(FILT_NUM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
  .req_num(req_num), .req_priv(req_priv), .req_wdata(req_wdata),
  .req_rdata(req_rdata), .req_denied(req_denied), .amask_o(amask_o),
  .filt_q(filt_q)
);

// File: tb/sim_amask_regs.sv
module sim_amask_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_vld = 1'b0, req_wr = 1'b0, req_priv = 1'b0;
  logic [9:0] req_num = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] req_rdata, amask_o;
  logic req_denied;

  int n_chk = 0, n_bad = 0;
  logic [63:0] m_mask, m_filt;

  always #5 clk = ~clk;

  amask_regs u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_num(req_num), .req_priv(req_priv), .req_wdata(req_wdata),
    .req_rdata(req_rdata), .req_denied(req_denied), .amask_o(amask_o)
  );

  task automatic chk(input bit good, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input bit vld, input bit wr, input bit priv, input logic [9:0] num, input logic [63:0] d);
    logic [63:0] e_rd;
    bit e_den, is_mask, is_filt;
    @(negedge clk);
    chk(amask_o == m_mask, "R9 amask_o", amask_o, m_mask);
    req_vld = vld; req_wr = wr; req_priv = priv; req_num = num; req_wdata = d;
    e_den   = vld && !priv && (num == 10'd29 || num == 10'd157);
    is_mask = vld && !e_den && (num == 10'd13 || num == 10'd29);
    is_filt = vld && !e_den && num == 10'd157;
    e_rd = is_mask ? m_mask : (is_filt ? m_filt : 64'd0);
    #1;
    chk(req_denied == e_den, e_den ? "R6 denied" : "R8 denied", {63'd0, req_denied}, {63'd0, e_den});
    chk(req_rdata == e_rd, wr ? "R7 old value" : (is_filt ? "R4 read" : "R5 read"), req_rdata, e_rd);
    @(posedge clk);
    if (is_mask && wr) m_mask = priv ? d : (d & m_filt);
    if (is_filt && wr) m_filt = d;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [9:0] nums [6];
    nums = '{10'd13, 10'd29, 10'd157, 10'd12, 10'd30, 10'd0};
    m_mask = '1; m_filt = '0;
    repeat (3) @(posedge clk);
    #2;
    chk(amask_o == 64'hFFFF_FFFF_FFFF_FFFF, "R1 mask reset", amask_o, '1);
    rst_n = 1'b1;
    op(1, 0, 1, 10'd157, 64'd0);
    chk(req_rdata == 64'd0, "R1 filter reset", req_rdata, 64'd0);
    op(1, 1, 0, 10'd13, 64'hDEAD_BEEF_0123_4567);
    op(1, 0, 0, 10'd13, 64'd0);
    chk(amask_o == 64'd0, "R2 zero filter", amask_o, 64'd0);
    for (int k = 0; k < 12; k++) begin
      for (int n = 0; n < 6; n++)
        for (int p = 0; p < 2; p++)
          for (int w = 0; w < 2; w++) begin
            logic [63:0] d;
            d = {32'(k * 32'h9E37_79B9 + n * 32'h85EB_CA6B), 32'(~(k * 32'h27D4_EB2F) ^ (p * 32'h1656_67B1 + w))};
            op(1, w[0], p[0], nums[n], d);
          end
      op(0, 1, 1, 10'd13, 64'h0);
      op(0, 1, 1, 10'd157, 64'hFFFF);
    end
    op(1, 1, 1, 10'd157, 64'h00FF_00FF_F0F0_0F0F);
    op(1, 1, 1, 10'd29, 64'h1234_5678_9ABC_DEF0);
    op(1, 1, 0, 10'd13, 64'hFFFF_FFFF_FFFF_FFFF);
    op(1, 0, 1, 10'd29, 64'd0);
    chk(amask_o == 64'h00FF_00FF_F0F0_0F0F, "R2 filtered all-ones", amask_o, 64'h00FF_00FF_F0F0_0F0F);
    op(1, 1, 0, 10'd29, 64'd0);
    op(1, 1, 0, 10'd157, 64'hFFFF_FFFF_FFFF_FFFF);
    op(1, 0, 1, 10'd157, 64'd0);
    chk(req_rdata == 64'h00FF_00FF_F0F0_0F0F, "R6 filter unchanged", req_rdata, 64'h00FF_00FF_F0F0_0F0F);
    op(1, 1, 1, 10'd13, 64'hA5A5_A5A5_5A5A_5A5A);
    op(1, 0, 0, 10'd13, 64'd0);
    chk(req_rdata == 64'hA5A5_A5A5_5A5A_5A5A, "R3 priv alias 13", req_rdata, 64'hA5A5_A5A5_5A5A_5A5A);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule